// File: doc/BRIEF.md
# Calendar-free time-of-day counter with alarm and interrupt flags

This block keeps elapsed time as a day count plus hours, minutes and seconds, advancing once per pulse on a 1 Hz tick input. Software reaches it through a small word-addressed register port with 16-bit data. It can set any time field directly, program an alarm, and read everything back in the same cycle.

An interrupt status register collects three kinds of event. The first is an alarm match. The second is the 1 Hz tick itself. The third is nine periodic tick sources that come in on a vector input. Each flag is set by its source whether or not it is enabled, and software clears it by writing a one to it. A single interrupt request line is high while any flag is set together with its matching bit in the enable register.

Top module: `rtc_core`

## Requirements
- R1: After reset every time field, alarm field, status bit and enable bit reads 0, and `irq` is low.
- R2: Each `tick_1hz` pulse advances seconds by one. From 59, seconds go to 0 and minutes advance by one.
- R3: Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day count.
- R4: The 9-bit day count wraps from 511 to 0 when a carry reaches it.
- R5: Register map by word index: 0 hour/minute, 1 seconds, 2 alarm hour/minute, 3 alarm seconds, 5 status, 6 enable, 8 day, 9 alarm day. Hour/minute words hold the hour in bits [15:8] and the minute in bits [7:0], stored as 5 and 6 bits. Seconds are stored as 6 bits and days as 9 bits. Unstored bits read 0. A write takes effect on the next clock edge.
- R6: A write to a time register in the same cycle as a tick loads the written value into that register instead of the incremented value.
- R7: Status bit 2 (alarm) sets on the tick after which day, hour, minute and second all equal the alarm registers. No other tick sets it.
- R8: Status bit 4 sets on every tick. Input `per_tick[0]` sets status bit 7, and `per_tick[k]` for k = 1..8 sets status bit 7+k.
- R9: A write to status clears exactly the bits written as 1. Bits written as 0 are unchanged, and 0xFFFF clears all of them.
- R10: When a source sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R11: Flags set whether or not they are enabled. `irq` is high exactly when some status bit and its enable bit are both 1.
- R12: With no tick and no write, the time registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| per_tick | input | 9 | Periodic event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word index of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A wrong carry or rollover shows at the ports on the same edge as the tick that causes it. The bench therefore reads the fields right after each boundary tick and does not wait for the error to spread through later counts. A wrong alarm compare, or a wrong status set/clear order, shows as a single status bit or as `irq` one cycle after the event. The bench places its stimulus so that each decision has one observable cycle, and it checks that cycle.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DAY_W    = 9,
  parameter int SEC_LAST = 59,
  parameter int MIN_LAST = 59,
  parameter int HR_LAST  = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic [8:0]  per_tick,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq
);
  localparam int SEC_W = $clog2(SEC_LAST + 1);
  localparam int MIN_W = $clog2(MIN_LAST + 1);
  localparam int HR_W  = $clog2(HR_LAST + 1);
  localparam logic [SEC_W-1:0] SEC_L = SEC_W'(SEC_LAST);
  localparam logic [MIN_W-1:0] MIN_L = MIN_W'(MIN_LAST);
  localparam logic [HR_W-1:0]  HR_L  = HR_W'(HR_LAST);

  localparam logic [3:0] A_HM = 4'd0, A_SEC = 4'd1, A_AHM = 4'd2, A_ASEC = 4'd3,
                         A_ST = 4'd5, A_IE = 4'd6, A_DAY = 4'd8, A_ADAY = 4'd9;

  logic [SEC_W-1:0] sec_q, asec_q, sec_inc, sec_d;
  logic [MIN_W-1:0] min_q, amin_q, min_inc, min_d;
  logic [HR_W-1:0]  hr_q,  ahr_q,  hr_inc,  hr_d;
  logic [DAY_W-1:0] day_q, aday_q, day_inc, day_d;
  logic [15:0]      st_q, ie_q, st_set, st_clr;
  logic             sec_wrap, min_wrap, hr_wrap, alarm_hit;

  wire w_hm  = wr_en && addr == A_HM;
  wire w_sec = wr_en && addr == A_SEC;
  wire w_day = wr_en && addr == A_DAY;

  assign sec_wrap = sec_q >= SEC_L;
  assign min_wrap = min_q >= MIN_L;
  assign hr_wrap  = hr_q  >= HR_L;

  assign sec_inc = sec_wrap ? '0 : sec_q + 1'b1;
  assign min_inc = !sec_wrap ? min_q : (min_wrap ? '0 : min_q + 1'b1);
  assign hr_inc  = !(sec_wrap && min_wrap) ? hr_q : (hr_wrap ? '0 : hr_q + 1'b1);
  assign day_inc = (sec_wrap && min_wrap && hr_wrap) ? day_q + 1'b1 : day_q;

  assign sec_d = w_sec ? wdata[SEC_W-1:0]     : tick_1hz ? sec_inc : sec_q;
  assign min_d = w_hm  ? wdata[MIN_W-1:0]     : tick_1hz ? min_inc : min_q;
  assign hr_d  = w_hm  ? wdata[8 +: HR_W]     : tick_1hz ? hr_inc  : hr_q;
  assign day_d = w_day ? wdata[DAY_W-1:0]     : tick_1hz ? day_inc : day_q;

  assign alarm_hit = tick_1hz && sec_d == asec_q && min_d == amin_q &&
                     hr_d == ahr_q && day_d == aday_q;

  assign st_set = {per_tick[8:1], per_tick[0], 2'b00, tick_1hz, 1'b0, alarm_hit, 2'b00};
  assign st_clr = (wr_en && addr == A_ST) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0; min_q  <= '0; hr_q  <= '0; day_q  <= '0;
      asec_q <= '0; amin_q <= '0; ahr_q <= '0; aday_q <= '0;
      st_q   <= '0; ie_q   <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
      hr_q  <= hr_d;
      day_q <= day_d;
      st_q  <= (st_q & ~st_clr) | st_set;
      if (wr_en) begin
        case (addr)
          A_AHM:  begin amin_q <= wdata[MIN_W-1:0]; ahr_q <= wdata[8 +: HR_W]; end
          A_ASEC: asec_q <= wdata[SEC_W-1:0];
          A_ADAY: aday_q <= wdata[DAY_W-1:0];
          A_IE:   ie_q   <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_HM:    rdata = {8'(hr_q), 8'(min_q)};
      A_SEC:   rdata = 16'(sec_q);
      A_AHM:   rdata = {8'(ahr_q), 8'(amin_q)};
      A_ASEC:  rdata = 16'(asec_q);
      A_ST:    rdata = st_q;
      A_IE:    rdata = ie_q;
      A_DAY:   rdata = 16'(day_q);
      A_ADAY:  rdata = 16'(aday_q);
      default: rdata = '0;
    endcase
  end

  assign irq = |(st_q & ie_q);
endmodule

module rtc_core_chk #(
  parameter int DAY_W = 9,
  parameter int SEC_W = 6,
  parameter int MIN_W = 6,
  parameter int HR_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_1hz,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [15:0]      wdata,
  input logic [SEC_W-1:0] sec_q,
  input logic [MIN_W-1:0] min_q,
  input logic [HR_W-1:0]  hr_q,
  input logic [DAY_W-1:0] day_q,
  input logic [15:0]      st_q,
  input logic             irq
);
  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_en && sec_q == 6'd59) |=> (sec_q == '0));

  // R4
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_en && sec_q == 6'd59 && min_q == 6'd59 && hr_q == 5'd23 && &day_q)
    |=> (day_q == '0));

  // R6
  sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd1) |=> (sec_q == $past(wdata[SEC_W-1:0])));

  // R8
  tick_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> st_q[4]);

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd5 && wdata[4] && !tick_1hz) |=> !st_q[4]);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q) && $stable(day_q)));

  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> !irq);
endmodule

bind rtc_core rtc_core_chk #(.DAY_W(DAY_W), .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .day_q(day_q),
  .st_q(st_q), .irq(irq));

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, tick_1hz = 0, wr_en = 0;
  logic [8:0] per_tick = '0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  rtc_core u0 (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .per_tick(per_tick),
               .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1;
    @(posedge clk); #1 tick_1hz = 0;
  endtask

  task automatic set_time(input logic [15:0] day, input logic [15:0] hm, input logic [15:0] s);
    wr(4'd8, day); wr(4'd0, hm); wr(4'd1, s);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 10; a++) begin
      rd(a[3:0], v); check("R1 reset reg", v, 16'h0);
    end
    check("R1 reset irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_count();
    logic [15:0] v;
    set_time(16'd0, 16'h0000, 16'd58);
    tick(); rd(4'd1, v); check("R2 sec step", v, 16'd59);
    tick(); rd(4'd1, v); check("R2 sec wrap", v, 16'd0);
    rd(4'd0, v); check("R2 minute carry", v, 16'h0001);
    repeat (5) @(posedge clk);
    rd(4'd1, v); check("R12 hold sec", v, 16'd0);
    rd(4'd0, v); check("R12 hold hm", v, 16'h0001);
  endtask

  task automatic t_carry();
    logic [15:0] v;
    set_time(16'd5, 16'h053B, 16'd59);
    tick(); rd(4'd0, v); check("R3 min wrap hour carry", v, 16'h0600);
    set_time(16'd5, 16'h173B, 16'd59);
    tick(); rd(4'd0, v); check("R3 hour wrap", v, 16'h0000);
    rd(4'd8, v); check("R3 day carry", v, 16'd6);
  endtask

  task automatic t_daywrap();
    logic [15:0] v;
    set_time(16'd511, 16'h173B, 16'd59);
    tick(); rd(4'd8, v); check("R4 day wrap", v, 16'd0);
  endtask

  task automatic t_map();
    logic [15:0] v;
    wr(4'd0, 16'hFFFF); rd(4'd0, v); check("R5 hm packing", v, 16'h1F3F);
    wr(4'd8, 16'hFFFF); rd(4'd8, v); check("R5 day width", v, 16'h01FF);
    wr(4'd1, 16'hFFFF); rd(4'd1, v); check("R5 sec width", v, 16'h003F);
    wr(4'd2, 16'h0A1B); rd(4'd2, v); check("R5 alarm hm", v, 16'h0A1B);
    rd(4'd4, v); check("R5 unmapped reads zero", v, 16'h0);
  endtask

  task automatic t_prio();
    logic [15:0] v;
    set_time(16'd0, 16'h0102, 16'd20);
    @(negedge clk); tick_1hz = 1; wr_en = 1; addr = 4'd1; wdata = 16'd40;
    @(posedge clk); #1 tick_1hz = 0; wr_en = 0;
    rd(4'd1, v); check("R6 write beats tick", v, 16'd40);
    rd(4'd0, v); check("R6 other fields unchanged", v, 16'h0102);
  endtask

  task automatic t_alarm();
    logic [15:0] v;
    wr(4'd6, 16'h0000);
    wr(4'd9, 16'd3); wr(4'd2, 16'h0102); wr(4'd3, 16'd5);
    set_time(16'd3, 16'h0102, 16'd3);
    wr(4'd5, 16'hFFFF);
    tick(); rd(4'd5, v); check("R7 no alarm before match", v & 16'h0004, 16'h0);
    tick(); rd(4'd5, v); check("R7 alarm on match", v & 16'h0004, 16'h0004);
    check("R11 disabled flag no irq", {15'b0, irq}, 16'h0);
    wr(4'd6, 16'h0004);
    check("R11 enabled flag irq", {15'b0, irq}, 16'h1);
    wr(4'd5, 16'h0004); rd(4'd5, v);
    check("R9 alarm cleared", v & 16'h0004, 16'h0);
    check("R9 1hz kept", v & 16'h0010, 16'h0010);
    check("R11 irq drops", {15'b0, irq}, 16'h0);
    tick(); rd(4'd5, v); check("R7 no alarm after match", v & 16'h0004, 16'h0);
  endtask

  task automatic t_periodic();
    logic [15:0] v;
    wr(4'd6, 16'h0000);
    wr(4'd5, 16'hFFFF);
    @(negedge clk); per_tick = 9'b0_0000_0101;
    @(posedge clk); #1 per_tick = '0;
    rd(4'd5, v); check("R8 periodic map", v, 16'h0280);
    @(negedge clk); per_tick = 9'b1_0000_0000;
    @(posedge clk); #1 per_tick = '0;
    rd(4'd5, v); check("R8 top periodic bit", v, 16'h8280);
    wr(4'd5, 16'h0000); rd(4'd5, v); check("R9 zero write no effect", v, 16'h8280);
    wr(4'd6, 16'h0010);
    check("R11 unmatched enable", {15'b0, irq}, 16'h0);
    tick(); check("R11 tick flag raises irq", {15'b0, irq}, 16'h1);
    wr(4'd5, 16'hFFFF); rd(4'd5, v); check("R9 all ones clears", v, 16'h0);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    wr(4'd5, 16'hFFFF);
    @(negedge clk); tick_1hz = 1; wr_en = 1; addr = 4'd5; wdata = 16'h0010;
    @(posedge clk); #1 tick_1hz = 0; wr_en = 0;
    rd(4'd5, v); check("R10 set beats clear", v & 16'h0010, 16'h0010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_count();
    t_carry();
    t_daywrap();
    t_map();
    t_prio();
    t_alarm();
    t_periodic();
    t_setwins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule